// File: doc/BRIEF.md
# Dual-Pipe Issue Hazard Scoreboard

This block sits between decode and execute in an in-order core with two execution pipes, called A and B. Each cycle it sees up to two decoded instructions in program order (slot 0 older, slot 1 younger). It decides which of them may leave decode and which pipe each one enters. It only reasons about timing. It records, for every architectural register, the class of the instruction that last wrote it and how many cycles have passed since then. It also runs two busy timers for the non-pipelined integer divider and the shared floating-point divide/square-root unit.

A consumer may issue once the elapsed time on each of its source registers reaches the required latency. That latency is the producer class's default result latency, unless a forwarding path between the producer and consumer kinds shortens it. Grants are combinational on the presented slots and the registered scoreboard. An accepted instruction updates the scoreboard at the next clock edge. A stalled instruction stays on the inputs until it is granted.

Register indices are 6 bits wide. Index 0 is the hard-wired zero register, and the other indices (integer and FP files together) are ordinary registers.

Top module: `hz_issue_sb`

## Requirements
- R1: Class codes are: 0 int load, 1 FP load, 2 int store, 3 FP store, 4 branch, 5 jump/call, 6 int multiply, 7 int divide, 8 int ALU, 9 constant/no-op, 10 single FMA-type, 11 double FMA-type, 12 FP convert/compare/move, 13 single divide/sqrt, 14 double divide/sqrt, 15 int-to-FP move, 16 FP-to-int move. Classes 0-3, 15 and 16 go only to pipe A, reported as `pipe_o` bit 0.
- R2: Classes 4-7 and 10-14 go only to pipe B, reported as `pipe_o` bit 1.
- R3: Classes 8 and 9 may use either pipe. In slot 0 such a class takes pipe A, except that it takes pipe B when slot 1 is valid and holds an A-only class. In slot 1 it takes the pipe that slot 0 left free. Two flexible classes therefore land on A then B.
- R4: A pipe accepts at most one instruction per cycle. Slot 1 is granted only when slot 0 is granted in the same cycle.
- R5: A source becomes usable a fixed number of cycles after its producer issues: int load 3, FP load 2, jump 1, multiply 3, int divide 16, ALU 2, constant 1, single FMA 5, double FMA 7, FP convert/compare/move 3, FP divide 27 (single) or 56 (double), each cross-file move 3. Stores and branches write nothing.
- R6: A source of an ALU op or branch, or the store-data operand of an int store, is usable 1 cycle after issue when it was produced by an int load, ALU op, multiply or FP-to-int move.
- R7: A source is usable 2 cycles after issue when an int-to-FP move or an FP convert/compare/move feeds a class from 10 to 14, or when an FP convert/compare/move feeds an ALU op, a branch or int store data.
- R8: The store-data forwarding of R6 and R7 applies only to `rs2` of an int store (class 2) with `sdat_i` set. A store's address source, an untagged `rs2`, and any FP store source use the default latency.
- R9: After an int divide issues, no other int divide is granted for the next 15 cycles, whatever the register dependencies.
- R10: Single and double divide/sqrt share one unit. It stays busy for 26 (single) or 55 (double) cycles after issue.
- R11: Slot 1 is not granted when either of its sources equals the nonzero destination of slot 0, provided slot 0's class writes a register.
- R12: Register index 0 never causes a stall, and a write to it is not recorded.
- R13: Synchronous active-high reset makes every register ready at once and frees both dividers.
- R14: An invalid slot, or a class code above 16, is never granted. Grants are valid in the same cycle the slots are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 2 | Per-slot valid |
| cls_i | input | 2x5 | Per-slot class code |
| rd_i | input | 2x6 | Per-slot destination index |
| rs1_i | input | 2x6 | Per-slot first source index |
| rs2_i | input | 2x6 | Per-slot second source index |
| sdat_i | input | 2 | Per-slot tag: rs2 is store data |
| grant_o | output | 2 | Per-slot issue grant |
| pipe_o | output | 2 | Per-slot pipe, 0 = A, 1 = B |

## Verification
A corrupt age counter or stale producer class surfaces directly as a grant that comes one or more cycles early or late for a dependent consumer. The bench measures that distance as an exact cycle count for every producer and consumer class pair. A divider timer that is loaded with the wrong length, or that never clears, shows up as a wrong spacing between two divides, or as a divide that is never granted; the watchdog bounds that case. Routing errors are combinational, so they appear in the first cycle a slot pair is presented.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int CLS_W = 5;

    typedef enum logic [CLS_W-1:0] {
        C_LD   = 5'd0,  C_FLD  = 5'd1,  C_ST   = 5'd2,  C_FST  = 5'd3,
        C_BR   = 5'd4,  C_JMP  = 5'd5,  C_MUL  = 5'd6,  C_DIV  = 5'd7,
        C_ALU  = 5'd8,  C_IMM  = 5'd9,  C_FMAS = 5'd10, C_FMAD = 5'd11,
        C_FOTH = 5'd12, C_FDVS = 5'd13, C_FDVD = 5'd14, C_I2F  = 5'd15,
        C_F2I  = 5'd16
    } cls_e;

    localparam int LAT_LD   = 3;
    localparam int LAT_FLD  = 2;
    localparam int LAT_JMP  = 1;
    localparam int LAT_MUL  = 3;
    localparam int LAT_DIV  = 16;
    localparam int LAT_ALU  = 2;
    localparam int LAT_IMM  = 1;
    localparam int LAT_FMAS = 5;
    localparam int LAT_FMAD = 7;
    localparam int LAT_FOTH = 3;
    localparam int LAT_FDVS = 27;
    localparam int LAT_FDVD = 56;
    localparam int LAT_XMOV = 3;
    localparam int BYP_INT  = 1;
    localparam int BYP_FP   = 2;

    localparam int HOLD_DIV  = LAT_DIV - 1;
    localparam int HOLD_FDVS = LAT_FDVS - 1;
    localparam int HOLD_FDVD = LAT_FDVD - 1;

    localparam int LAT_MAX = LAT_FDVD;
    localparam int AGE_W   = $clog2(LAT_MAX + 1);
    localparam int HOLD_W  = $clog2(HOLD_FDVD + 1);

    typedef enum logic { PIPE_A = 1'b0, PIPE_B = 1'b1 } pipe_e;

    typedef struct packed {
        logic              to_a;
        logic              to_b;
        logic              dest;
        logic              int_cons;
        logic              st_int;
        logic              fp_cons;
        logic              idiv;
        logic              fdiv;
        logic [HOLD_W-1:0] hold;
    } cls_info_t;

    function automatic logic [AGE_W-1:0] cls_lat(input logic [CLS_W-1:0] c);
        int l;
        case (c)
            C_LD:           l = LAT_LD;
            C_FLD:          l = LAT_FLD;
            C_JMP:          l = LAT_JMP;
            C_MUL:          l = LAT_MUL;
            C_DIV:          l = LAT_DIV;
            C_ALU:          l = LAT_ALU;
            C_FMAS:         l = LAT_FMAS;
            C_FMAD:         l = LAT_FMAD;
            C_FOTH:         l = LAT_FOTH;
            C_FDVS:         l = LAT_FDVS;
            C_FDVD:         l = LAT_FDVD;
            C_I2F, C_F2I:   l = LAT_XMOV;
            default:        l = LAT_IMM;
        endcase
        return AGE_W'(l);
    endfunction

    function automatic logic writes_reg(input logic [CLS_W-1:0] c);
        return (c <= C_F2I) && (c != C_ST) && (c != C_FST) && (c != C_BR);
    endfunction

    function automatic logic int_fwd_src(input logic [CLS_W-1:0] c);
        return (c == C_LD) || (c == C_ALU) || (c == C_MUL) || (c == C_F2I);
    endfunction

    function automatic logic a_only(input logic [CLS_W-1:0] c);
        return (c <= C_FST) || (c == C_I2F) || (c == C_F2I);
    endfunction

endpackage

// File: rtl/hz_class_dec.sv
module hz_class_dec
    import hz_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output cls_info_t        info_o
);
    always_comb begin
        info_o          = '0;
        info_o.dest     = writes_reg(cls_i);
        info_o.to_a     = a_only(cls_i) || (cls_i == C_ALU) || (cls_i == C_IMM);
        info_o.to_b     = (cls_i <= C_F2I) && !a_only(cls_i);
        info_o.int_cons = (cls_i == C_ALU) || (cls_i == C_BR);
        info_o.st_int   = (cls_i == C_ST);
        info_o.fp_cons  = (cls_i >= C_FMAS) && (cls_i <= C_FDVD);
        case (cls_i)
            C_DIV: begin
                info_o.idiv = 1'b1;
                info_o.hold = HOLD_W'(HOLD_DIV);
            end
            C_FDVS: begin
                info_o.fdiv = 1'b1;
                info_o.hold = HOLD_W'(HOLD_FDVS);
            end
            C_FDVD: begin
                info_o.fdiv = 1'b1;
                info_o.hold = HOLD_W'(HOLD_FDVD);
            end
            default: info_o.hold = '0;
        endcase
    end
endmodule

// File: rtl/hz_src_check.sv
module hz_src_check
    import hz_pkg::*;
#(
    parameter int IDXW = 6
) (
    input  logic [IDXW-1:0]  idx_i,
    input  logic [AGE_W-1:0] age_i,
    input  logic [CLS_W-1:0] pcls_i,
    input  logic             int_cons_i,
    input  logic             fp_cons_i,
    output logic             ok_o
);
    logic [AGE_W-1:0] need;

    always_comb begin
        need = cls_lat(pcls_i);
        if (int_cons_i && int_fwd_src(pcls_i)) need = AGE_W'(BYP_INT);
        if (int_cons_i && (pcls_i == C_FOTH))  need = AGE_W'(BYP_FP);
        if (fp_cons_i && ((pcls_i == C_FOTH) || (pcls_i == C_I2F)))
            need = AGE_W'(BYP_FP);
        ok_o = (idx_i == '0) || (age_i >= need);
    end
endmodule

// File: rtl/hz_busy_timer.sv
module hz_busy_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] len_i,
    output logic         busy_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = len_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/hz_issue_sb.sv
module hz_issue_sb
    import hz_pkg::*;
#(
    parameter  int NREG = 64,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                vld_i,
    input  logic [1:0][CLS_W-1:0]     cls_i,
    input  logic [1:0][IDXW-1:0]      rd_i,
    input  logic [1:0][IDXW-1:0]      rs1_i,
    input  logic [1:0][IDXW-1:0]      rs2_i,
    input  logic [1:0]                sdat_i,
    output logic [1:0]                grant_o,
    output logic [1:0]                pipe_o
);
    localparam logic [AGE_W-1:0] AGE_SAT = '1;
    localparam int NSLOT = 2;
    localparam int NSRC  = 2;
    localparam int NUNIT = 2;

    typedef struct packed {
        logic [NREG-1:0][AGE_W-1:0] age;
        logic [NREG-1:0][CLS_W-1:0] pcls;
    } sb_t;

    sb_t st_d, st_q;

    cls_info_t [NSLOT-1:0]                info;
    logic      [NSLOT-1:0][NSRC-1:0]      src_ok;
    logic      [NSLOT-1:0][NSRC-1:0][IDXW-1:0] sidx;
    logic      [NSLOT-1:0][NSRC-1:0]      sint;
    logic      [NUNIT-1:0]                ubusy;
    logic      [NUNIT-1:0]                ustart;
    logic      [NUNIT-1:0][HOLD_W-1:0]    ulen;
    logic      [NSLOT-1:0]                g;
    logic      [NSLOT-1:0]                p;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        hz_class_dec u_dec (
            .cls_i  (cls_i[s]),
            .info_o (info[s])
        );
        for (genvar j = 0; j < NSRC; j++) begin : g_src
            if (j == 0) begin : g_a
                assign sidx[s][j] = rs1_i[s];
                assign sint[s][j] = info[s].int_cons;
            end else begin : g_b
                assign sidx[s][j] = rs2_i[s];
                assign sint[s][j] = info[s].int_cons || (info[s].st_int && sdat_i[s]);
            end
            hz_src_check #(.IDXW(IDXW)) u_chk (
                .idx_i      (sidx[s][j]),
                .age_i      (st_q.age[sidx[s][j]]),
                .pcls_i     (st_q.pcls[sidx[s][j]]),
                .int_cons_i (sint[s][j]),
                .fp_cons_i  (info[s].fp_cons),
                .ok_o       (src_ok[s][j])
            );
        end
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        logic [NSLOT-1:0] use_u;
        for (genvar s = 0; s < NSLOT; s++) begin : g_use
            if (u == 0) begin : g_i
                assign use_u[s] = g[s] && info[s].idiv;
            end else begin : g_f
                assign use_u[s] = g[s] && info[s].fdiv;
            end
        end
        assign ustart[u] = |use_u;
        assign ulen[u]   = use_u[0] ? info[0].hold : info[1].hold;
        hz_busy_timer #(.W(HOLD_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .start_i (ustart[u]),
            .len_i   (ulen[u]),
            .busy_o  (ubusy[u])
        );
    end

    // Issue decision: routing, register readiness, unit availability.
    always_comb begin
        logic [NSLOT-1:0] unit_ok;
        logic [NSLOT-1:0] flex;
        logic             raw1;
        for (int s = 0; s < NSLOT; s++) begin
            unit_ok[s] = !(info[s].idiv && ubusy[0]) && !(info[s].fdiv && ubusy[1]);
            flex[s]    = info[s].to_a && info[s].to_b;
        end
        if (flex[0])
            p[0] = (vld_i[1] && info[1].to_a && !info[1].to_b) ? PIPE_B : PIPE_A;
        else
            p[0] = info[0].to_a ? PIPE_A : PIPE_B;
        if (flex[1])
            p[1] = ~p[0];
        else
            p[1] = info[1].to_a ? PIPE_A : PIPE_B;
        raw1 = info[0].dest && (rd_i[0] != '0) &&
               ((rs1_i[1] == rd_i[0]) || (rs2_i[1] == rd_i[0]));
        g[0] = vld_i[0] && (info[0].to_a || info[0].to_b) && (&src_ok[0]) && unit_ok[0];
        g[1] = vld_i[1] && g[0] && (info[1].to_a || info[1].to_b) && (&src_ok[1]) &&
               unit_ok[1] && !raw1 && (p[1] != p[0]);
    end

    assign grant_o = g;
    assign pipe_o  = p;

    // Scoreboard next state: age all entries, then record accepted writers in order.
    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NREG; r++) begin
            if (st_q.age[r] != AGE_SAT) st_d.age[r] = st_q.age[r] + 1'b1;
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (g[s] && info[s].dest && (rd_i[s] != '0)) begin
                st_d.age[rd_i[s]]  = AGE_W'(1);
                st_d.pcls[rd_i[s]] = cls_i[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                st_q.age[r]  <= AGE_SAT;
                st_q.pcls[r] <= C_IMM;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hz_sb_chk.sv
module hz_sb_chk
    import hz_pkg::*;
#(
    parameter int IDXW = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            vld_i,
    input logic [1:0][CLS_W-1:0] cls_i,
    input logic [1:0][IDXW-1:0]  rd_i,
    input logic [1:0][IDXW-1:0]  rs1_i,
    input logic [1:0][IDXW-1:0]  rs2_i,
    input logic [1:0]            grant_o,
    input logic [1:0]            pipe_o
);
    localparam int GW = 7;
    logic [GW-1:0] since_idiv, since_fdiv;
    logic          idiv_now, fdiv_now;

    assign idiv_now = (grant_o[0] && cls_i[0] == C_DIV) || (grant_o[1] && cls_i[1] == C_DIV);
    assign fdiv_now = (grant_o[0] && (cls_i[0] == C_FDVS || cls_i[0] == C_FDVD)) ||
                      (grant_o[1] && (cls_i[1] == C_FDVS || cls_i[1] == C_FDVD));

    always_ff @(posedge clk) begin
        if (rst) begin
            since_idiv <= '1;
            since_fdiv <= '1;
        end else begin
            since_idiv <= idiv_now ? GW'(1) : (since_idiv == '1 ? since_idiv : since_idiv + 1'b1);
            since_fdiv <= fdiv_now ? GW'(1) : (since_fdiv == '1 ? since_fdiv : since_fdiv + 1'b1);
        end
    end

    AST_SLOT1_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        grant_o[1] |-> grant_o[0]);                                        // R4
    AST_PIPES_DIFFER: assert property (@(posedge clk) disable iff (rst)
        (grant_o == 2'b11) |-> (pipe_o[0] != pipe_o[1]));                  // R4
    AST_A_ONLY_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (grant_o[0] && a_only(cls_i[0])) |-> (pipe_o[0] == PIPE_A));       // R1
    AST_B_ONLY_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (grant_o[0] && cls_i[0] <= C_F2I && !a_only(cls_i[0]) &&
         cls_i[0] != C_ALU && cls_i[0] != C_IMM) |-> (pipe_o[0] == PIPE_B)); // R2
    AST_GRANT_VALID: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~vld_i) == 2'b00);                                      // R14
    AST_SAME_CYCLE_RAW: assert property (@(posedge clk) disable iff (rst)
        (grant_o[1] && writes_reg(cls_i[0]) && rd_i[0] != '0) |->
        (rs1_i[1] != rd_i[0] && rs2_i[1] != rd_i[0]));                     // R11
    AST_IDIV_SPACING: assert property (@(posedge clk) disable iff (rst)
        idiv_now |-> (since_idiv >= GW'(LAT_DIV)));                        // R9
    AST_FDIV_SPACING: assert property (@(posedge clk) disable iff (rst)
        fdiv_now |-> (since_fdiv >= GW'(LAT_FDVS)));                       // R10
endmodule

bind hz_issue_sb hz_sb_chk #(.IDXW(IDXW)) u_sb_chk (
    .clk     (clk),
    .rst     (rst),
    .vld_i   (vld_i),
    .cls_i   (cls_i),
    .rd_i    (rd_i),
    .rs1_i   (rs1_i),
    .rs2_i   (rs2_i),
    .grant_o (grant_o),
    .pipe_o  (pipe_o)
);

// File: tb/sim_hz_issue_sb.sv
`timescale 1ns/1ps
module sim_hz_issue_sb;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      vld_i;
    logic [1:0][4:0] cls_i;
    logic [1:0][5:0] rd_i, rs1_i, rs2_i;
    logic [1:0]      sdat_i;
    logic [1:0]      grant_o, pipe_o;
    int              nchk = 0;
    int              nbad = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;

    hz_issue_sb u0 (
        .clk(clk), .rst(rst), .vld_i(vld_i), .cls_i(cls_i), .rd_i(rd_i),
        .rs1_i(rs1_i), .rs2_i(rs2_i), .sdat_i(sdat_i),
        .grant_o(grant_o), .pipe_o(pipe_o)
    );

    function automatic int blat(int c);
        case (c)
            0: return 3;  1: return 2;  5: return 1;  6: return 3;
            7: return 16; 8: return 2;  9: return 1;  10: return 5;
            11: return 7; 12: return 3; 13: return 27; 14: return 56;
            15: return 3; 16: return 3;
            default: return 1;
        endcase
    endfunction

    function automatic bit wr(int c);  return !(c == 2 || c == 3 || c == 4); endfunction
    function automatic bit aon(int c); return (c <= 3) || c == 15 || c == 16; endfunction
    function automatic bit flx(int c); return c == 8 || c == 9; endfunction

    // mode 0: consumer reads via rs1; 1: rs2 tagged store data; 2: no dependency
    function automatic int exp_gap(int pc, int cc, int mode, output string tag);
        int  e = 1;
        bit  ic, fc;
        tag = "R5";
        if (mode != 2 && wr(pc)) begin
            e  = blat(pc);
            ic = (cc == 8 || cc == 4 || (mode == 1 && cc == 2));
            fc = (cc >= 10 && cc <= 14);
            if (ic && (pc == 0 || pc == 8 || pc == 6 || pc == 16)) begin e = 1; tag = "R6"; end
            if (ic && pc == 12) begin e = 2; tag = "R7"; end
            if (fc && (pc == 15 || pc == 12)) begin e = 2; tag = "R7"; end
            if (cc == 2 || cc == 3) tag = "R8";
        end
        if (pc == 7 && cc == 7) begin
            if (e < 16) e = 16;
            tag = "R9";
        end
        if ((pc == 13 || pc == 14) && (cc == 13 || cc == 14)) begin
            if (e < blat(pc)) e = blat(pc);
            tag = "R10";
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        vld_i = '0; cls_i = '0; rd_i = '0; rs1_i = '0; rs2_i = '0; sdat_i = '0;
    endtask

    task automatic set_slot(int s, int c, int d, int a, int b, bit sd);
        vld_i[s] = 1'b1; cls_i[s] = 5'(c); rd_i[s] = 6'(d);
        rs1_i[s] = 6'(a); rs2_i[s] = 6'(b); sdat_i[s] = sd;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic run_gap(int pc, int cc, int mode);
        int    gap = 1;
        int    e;
        string tag;
        do_reset();
        set_slot(0, pc, 5, 0, 0, 1'b0);
        #1;
        if (!grant_o[0]) check(1'b0, "R13", 0, 1);
        @(negedge clk);
        idle();
        set_slot(0, cc, 6, (mode == 0) ? 5 : 0, (mode == 1) ? 5 : 0, mode == 1);
        forever begin
            #1;
            if (grant_o[0] || gap > 90) break;
            @(negedge clk);
            gap++;
        end
        e = exp_gap(pc, cc, mode, tag);
        check(gap == e, tag, gap, e);
        @(negedge clk); idle();
    endtask

    task automatic run_route(int c0, int c1);
        int    p0, p1, g1, act, exp;
        string tag;
        do_reset();
        set_slot(0, c0, 1, 0, 0, 1'b0);
        set_slot(1, c1, 2, 0, 0, 1'b0);
        p0  = flx(c0) ? (aon(c1) ? 1 : 0) : (aon(c0) ? 0 : 1);
        p1  = flx(c1) ? 1 - p0 : (aon(c1) ? 0 : 1);
        g1  = (p1 != p0);
        exp = 4 + g1 * 8 + p0 * 2 + (g1 ? p1 : 0);
        #1;
        act = int'(grant_o) * 4 + int'(pipe_o[0]) * 2 + (grant_o[1] ? int'(pipe_o[1]) : 0);
        if (flx(c0) || flx(c1)) tag = "R3";
        else if (!g1)           tag = "R4";
        else if (aon(c0))       tag = "R1";
        else                    tag = "R2";
        check(act == exp, tag, act, exp);
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        idle();
        // R13: reset state, every register ready immediately
        do_reset();
        set_slot(0, 8, 3, 5, 7, 1'b0); #1;
        check(grant_o == 2'b01, "R13", int'(grant_o), 1);
        // R13: reset mid-flight clears a long divide and its result
        do_reset();
        set_slot(0, 14, 5, 0, 0, 1'b0);
        @(negedge clk); idle(); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        set_slot(0, 13, 6, 5, 0, 1'b0); #1;
        check(grant_o[0] == 1'b1, "R13", int'(grant_o[0]), 1);
        // R14: invalid slot and illegal class
        do_reset();
        vld_i = 2'b10; cls_i[1] = 5'd8; #1;
        check(grant_o == 2'b00, "R14", int'(grant_o), 0);
        idle(); set_slot(0, 20, 1, 0, 0, 1'b0); #1;
        check(grant_o == 2'b00, "R14", int'(grant_o), 0);
        // R11: same-cycle dependence blocks slot 1; a store's rd field does not
        idle(); set_slot(0, 8, 3, 0, 0, 1'b0); set_slot(1, 8, 4, 0, 3, 1'b0); #1;
        check(grant_o == 2'b01, "R11", int'(grant_o), 1);
        idle(); set_slot(0, 2, 3, 0, 0, 1'b0); set_slot(1, 8, 4, 3, 0, 1'b0); #1;
        check(grant_o == 2'b11, "R11", int'(grant_o), 3);
        // R12: register 0 never creates a dependency
        idle(); set_slot(0, 8, 0, 0, 0, 1'b0); set_slot(1, 8, 4, 0, 0, 1'b0); #1;
        check(grant_o == 2'b11, "R12", int'(grant_o), 3);
        do_reset();
        set_slot(0, 14, 0, 0, 0, 1'b0);
        @(negedge clk); idle(); set_slot(0, 10, 6, 0, 0, 1'b0); #1;
        check(grant_o[0] == 1'b1, "R12", int'(grant_o[0]), 1);
        // R4: a stalled slot 0 blocks slot 1
        do_reset();
        set_slot(0, 7, 5, 0, 0, 1'b0);
        @(negedge clk); idle();
        set_slot(0, 7, 6, 0, 0, 1'b0); set_slot(1, 9, 4, 0, 0, 1'b0); #1;
        check(grant_o == 2'b00, "R4", int'(grant_o), 0);
        @(negedge clk); idle();
        // R9 / R10: divider spacing without any register dependency
        run_gap(7, 7, 2);
        run_gap(13, 14, 2);
        run_gap(14, 13, 2);
        run_gap(7, 13, 2);
        // R5..R10: every producer/consumer class pair through rs1
        for (int pc = 0; pc <= 16; pc++)
            for (int cc = 0; cc <= 16; cc++)
                run_gap(pc, cc, 0);
        // R8: tagged store-data operand of int and FP stores
        for (int pc = 0; pc <= 16; pc++) begin
            run_gap(pc, 2, 1);
            run_gap(pc, 3, 1);
        end
        // R1..R4: routing for every class pair
        for (int c0 = 0; c0 <= 16; c0++)
            for (int c1 = 0; c1 <= 16; c1++)
                run_route(c0, c1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule